// File: doc/BRIEF.md
# Edge-Interval Signal Qualifier

This block decides whether a demodulated data stream carries a real signal or only noise. Once enabled, it waits through a blanking period while the demodulator settles. It then measures the time between successive transitions of the data input. Time is counted in pulses of a slow tick strobe. Each measured interval must fall inside a window bounded by a programmable lower and upper tick count.

When a chosen number of consecutive intervals land inside the window, the block emits a one-cycle pass pulse. The surrounding receiver uses that pulse to enter its receive mode. If an interval ends too early, the block fails at that data edge. If the counter climbs to the upper bound before any edge arrives, the block fails at once. After a fail pulse the receiver returns to sleep.

After either result the block holds its final state and ignores its inputs. A new check needs the enable input to be dropped and raised again. The limits and the interval-count select are captured when a check starts, so the pins may change while the check runs.

Top module: `edge_interval_qualifier`

## Requirements
- R1: After reset, and whenever no check is running, `pass_pulse`, `fail_pulse`, `st_startup`, `st_check` and `st_done` are all low. At most one of the three state flags is high at any time.
- R2: One clock after `en` rises, a blanking phase begins and `st_startup` is high. The phase lasts `STARTUP_TICKS` tick pulses. Data transitions during this phase produce no result. `st_check` rises on the edge that samples the last blanking tick.
- R3: The first data transition after blanking only restarts the interval counter and is not judged. No pulse follows it.
- R4: A data transition whose interval count is below the captured lower limit causes a fail pulse, and `st_done` rises.
- R5: If the interval count reaches the captured upper limit with no data transition, `fail_pulse` rises one clock later, without waiting for a transition.
- R6: A transition whose interval count is at least the lower limit and below the upper limit is a good interval. The count restarts from zero for the next interval.
- R7: `nbits_sel` picks how many consecutive good intervals give a pass. The codes are 2'b00 for 3, 2'b01 for 6, 2'b10 for 9, and 2'b11 also for 9. The pass pulse follows the last required good interval and never an earlier one.
- R8: `pass_pulse` and `fail_pulse` are single-cycle pulses and are never high together. After a pulse, `st_done` stays high and data transitions have no effect until `en` is lowered.
- R9: `lim_lo`, `lim_hi` and `nbits_sel` are sampled when the check starts. Changing them during the check has no effect on its outcome.
- R10: Lowering `en` returns the block to idle on the next clock from any state, with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Starts a check when raised; lowering it aborts and returns to idle |
| tick | input | 1 | One-cycle strobe that advances the startup and interval counters |
| data_in | input | 1 | Asynchronous demodulated data stream |
| lim_lo | input | LIM_W | Lowest accepted interval, in ticks |
| lim_hi | input | LIM_W | Interval count that aborts the check |
| nbits_sel | input | 2 | Select for the number of good intervals required |
| pass_pulse | output | 1 | One-cycle pulse when enough consecutive good intervals are seen |
| fail_pulse | output | 1 | One-cycle pulse on a short or over-long interval |
| st_startup | output | 1 | Blanking phase active |
| st_check | output | 1 | Waiting for the first edge or measuring intervals |
| st_done | output | 1 | Result given; waiting for enable to drop |

## Verification
The bench builds the block with `STARTUP_TICKS` set to 4 and drives a tick on every fourth clock. This keeps each tick longer than the three-cycle edge-detection delay, so a transition placed right after a tick measures an exact whole number of ticks. With this setup the interval counts lower−1, lower, upper−1 and upper can all be reached in a few hundred cycles. Runs with an upper limit of 14 and of 63 (the widest value the 6-bit limit holds) exercise the early abort at both ends. Each of the four select codes is run through to its pass pulse.

// File: rtl/eiq_pkg.sv
package eiq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BLANK,
    S_ARM,
    S_MEAS,
    S_DONE
  } eiq_state_t;

  typedef enum logic [1:0] {
    V_SHORT,
    V_OK,
    V_LONG
  } eiq_verdict_t;

  // Number of consecutive good intervals needed for a given select code.
  function automatic logic [3:0] bits_target(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd3;
      2'b01:   return 4'd6;
      default: return 4'd9;
    endcase
  endfunction

  // Judge an interval count against the two window bounds.
  function automatic eiq_verdict_t judge(input logic [7:0] cnt,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
    if (cnt >= hi)     return V_LONG;
    else if (cnt < lo) return V_SHORT;
    else               return V_OK;
  endfunction

endpackage

// File: rtl/eiq_edge_sync.sv
module eiq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], din};
  end

  // sh[1] is the synchronized value, sh[2] its previous sample
  assign edge_pulse = sh[1] ^ sh[2];
endmodule

// File: rtl/eiq_tick_counter.sv
module eiq_tick_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/edge_interval_qualifier.sv
module edge_interval_qualifier
  import eiq_pkg::*;
#(
  parameter int LIM_W         = 6,
  parameter int STARTUP_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             data_in,
  input  logic [LIM_W-1:0] lim_lo,
  input  logic [LIM_W-1:0] lim_hi,
  input  logic [1:0]       nbits_sel,
  output logic             pass_pulse,
  output logic             fail_pulse,
  output logic             st_startup,
  output logic             st_check,
  output logic             st_done
);
  localparam int SU_W   = $clog2(STARTUP_TICKS + 1);
  localparam int GOOD_W = 4;
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_TICKS - 1);

  eiq_state_t       st, st_n;
  logic [LIM_W-1:0] lo_q, hi_q;
  logic [1:0]       sel_q;

  // named internal events
  logic             data_edge;
  logic             blanking, arming, measuring;
  logic [LIM_W-1:0] ivl_cnt;
  logic [SU_W-1:0]  su_cnt;
  logic [GOOD_W-1:0] good_cnt;
  eiq_verdict_t     verdict;
  logic             too_long, edge_short, edge_good, last_good;
  logic             fail_now, pass_now, blank_end;

  eiq_edge_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (data_in),
    .edge_pulse (data_edge)
  );

  assign blanking  = (st == S_BLANK);
  assign arming    = (st == S_ARM);
  assign measuring = (st == S_MEAS);

  eiq_tick_counter #(.W(SU_W)) u_blank_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!blanking),
    .inc   (tick),
    .count (su_cnt)
  );

  eiq_tick_counter #(.W(LIM_W)) u_ivl_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!measuring || data_edge),
    .inc   (tick),
    .count (ivl_cnt)
  );

  eiq_tick_counter #(.W(GOOD_W)) u_good_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!measuring),
    .inc   (edge_good),
    .count (good_cnt)
  );

  assign verdict    = judge(8'(ivl_cnt), 8'(lo_q), 8'(hi_q));
  assign too_long   = measuring && (verdict == V_LONG);
  assign edge_short = measuring && data_edge && (verdict == V_SHORT);
  assign edge_good  = measuring && data_edge && (verdict == V_OK);
  assign last_good  = edge_good && ((good_cnt + 1'b1) == bits_target(sel_q));
  assign fail_now   = en && (too_long || edge_short);
  assign pass_now   = en && last_good;
  assign blank_end  = blanking && tick && (su_cnt == SU_LAST);

  always_comb begin
    st_n = st;
    if (!en) st_n = S_IDLE;
    else begin
      case (st)
        S_IDLE:  st_n = S_BLANK;
        S_BLANK: if (blank_end) st_n = S_ARM;
        S_ARM:   if (data_edge) st_n = S_MEAS;
        S_MEAS:  if (fail_now || pass_now) st_n = S_DONE;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lo_q       <= '0;
      hi_q       <= '0;
      sel_q      <= '0;
      pass_pulse <= 1'b0;
      fail_pulse <= 1'b0;
    end else begin
      st         <= st_n;
      pass_pulse <= pass_now;
      fail_pulse <= fail_now;
      if (st == S_IDLE && en) begin
        lo_q  <= lim_lo;
        hi_q  <= lim_hi;
        sel_q <= nbits_sel;
      end
    end
  end

  assign st_startup = blanking;
  assign st_check   = arming || measuring;
  assign st_done    = (st == S_DONE);
endmodule

// File: rtl/eiq_checker.sv
module eiq_checker #(
  parameter int LIM_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             data_edge,
  input logic             measuring,
  input logic             edge_good,
  input logic             pass_now,
  input logic [LIM_W-1:0] ivl_cnt,
  input logic [LIM_W-1:0] lo_q,
  input logic [LIM_W-1:0] hi_q,
  input logic             st_startup,
  input logic             st_check,
  input logic             st_done,
  input logic             pass_pulse,
  input logic             fail_pulse
);
  // R1
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_startup, st_check, st_done}));

  // R2
  no_result_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_startup |-> (!pass_pulse && !fail_pulse));

  // R3
  arm_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_check && !measuring && data_edge) |=> (measuring && ivl_cnt == '0 && !pass_pulse && !fail_pulse));

  // R4
  short_edge_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && measuring && data_edge && ivl_cnt < lo_q) |=> (fail_pulse && st_done));

  // R5
  hard_limit_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && measuring && ivl_cnt >= hi_q) |=> fail_pulse);

  // R6
  good_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_good && !pass_now) |=> (measuring && ivl_cnt == '0 && !fail_pulse));

  // R8
  pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !pass_pulse);

  // R8
  fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !fail_pulse);

  // R8
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_pulse && fail_pulse));

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!st_startup && !st_check && !st_done && !pass_pulse && !fail_pulse));
endmodule

bind edge_interval_qualifier eiq_checker #(.LIM_W(LIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .data_edge  (data_edge),
  .measuring  (measuring),
  .edge_good  (edge_good),
  .pass_now   (pass_now),
  .ivl_cnt    (ivl_cnt),
  .lo_q       (lo_q),
  .hi_q       (hi_q),
  .st_startup (st_startup),
  .st_check   (st_check),
  .st_done    (st_done),
  .pass_pulse (pass_pulse),
  .fail_pulse (fail_pulse)
);

// File: tb/edge_interval_qualifier_tb.sv
`timescale 1ns/1ps
module edge_interval_qualifier_tb;
  localparam int LIM_W = 6;
  localparam int SU    = 4;
  localparam int TPER  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tick = 1'b0;
  logic data_in = 1'b0;
  logic [LIM_W-1:0] lim_lo = 6'd10;
  logic [LIM_W-1:0] lim_hi = 6'd14;
  logic [1:0] nbits_sel = 2'b00;
  logic pass_pulse, fail_pulse, st_startup, st_check, st_done;

  int n_checks = 0;
  int n_fail = 0;
  int n_pass_seen = 0;
  int n_fail_seen = 0;
  int phase = 0;

  always #10 clk = ~clk;

  edge_interval_qualifier #(.LIM_W(LIM_W), .STARTUP_TICKS(SU)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .data_in(data_in),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .nbits_sel(nbits_sel),
    .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
    .st_startup(st_startup), .st_check(st_check), .st_done(st_done)
  );

  always @(negedge clk) begin
    phase = (phase + 1) % TPER;
    tick = (phase == 0);
    if (pass_pulse) n_pass_seen++;
    if (fail_pulse) n_fail_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic cycles(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic toggle();
    #1 data_in = ~data_in;
  endtask

  task automatic send_ivl(input int k);
    wait_ticks(k);
    toggle();
  endtask

  task automatic stop_check();
    @(posedge clk); #1 en = 1'b0;
    cycles(4);
  endtask

  // enable, pass the blanking phase, give the arming edge
  task automatic start_check(input int lo, input int hi, input logic [1:0] sel);
    wait_ticks(1);
    #1;
    lim_lo = LIM_W'(lo); lim_hi = LIM_W'(hi); nbits_sel = sel; en = 1'b1;
    wait_ticks(SU);
    toggle();
  endtask

  task automatic t_reset();
    cycles(2);
    check(!pass_pulse && !fail_pulse, "R1 pulses after reset", pass_pulse + fail_pulse, 0);
    check(!st_startup && !st_check && !st_done, "R1 flags after reset",
          st_startup + st_check + st_done, 0);
  endtask

  task automatic t_select(input logic [1:0] sel, input int need);
    int p0 = n_pass_seen, f0 = n_fail_seen;
    start_check(10, 14, sel);
    for (int i = 0; i < need - 1; i++) send_ivl(12);
    wait_ticks(1);
    check(n_pass_seen == p0, "R7 no pass before last interval", n_pass_seen - p0, 0);
    check(st_check == 1'b1, "R6 still measuring", st_check, 1);
    send_ivl(11);
    cycles(5);
    check(n_pass_seen == p0 + 1, "R7 pass after required count", n_pass_seen - p0, 1);
    check(n_fail_seen == f0, "R7 no fail", n_fail_seen - f0, 0);
    stop_check();
  endtask

  task automatic t_short();
    int p0 = n_pass_seen, f0 = n_fail_seen;
    start_check(10, 14, 2'b01);
    send_ivl(12);
    send_ivl(9);
    cycles(5);
    check(n_fail_seen == f0 + 1, "R4 short interval fails", n_fail_seen - f0, 1);
    check(st_done == 1'b1, "R4 done after fail", st_done, 1);
    check(n_pass_seen == p0, "R4 no pass", n_pass_seen - p0, 0);
    stop_check();
  endtask

  task automatic t_window_edges();
    int p0 = n_pass_seen, f0 = n_fail_seen;
    start_check(10, 14, 2'b00);
    send_ivl(10);
    send_ivl(13);
    send_ivl(10);
    cycles(5);
    check(n_pass_seen == p0 + 1 && n_fail_seen == f0, "R6 lower and upper-1 accepted",
          n_pass_seen - p0, 1);
    stop_check();
  endtask

  task automatic t_abort(input int hi);
    int f0 = n_fail_seen, p0 = n_pass_seen;
    start_check(10, hi, 2'b10);
    wait_ticks(hi - 1);
    cycles(3);
    check(n_fail_seen == f0, "R5 no abort at upper-1", n_fail_seen - f0, 0);
    wait_ticks(1);
    cycles(3);
    check(n_fail_seen == f0 + 1, "R5 abort with no edge", n_fail_seen - f0, 1);
    toggle();
    cycles(6);
    check(n_fail_seen == f0 + 1 && n_pass_seen == p0, "R8 edge after abort ignored",
          n_fail_seen - f0, 1);
    check(st_done == 1'b1, "R8 done held", st_done, 1);
    stop_check();
  endtask

  task automatic t_blanking();
    int p0 = n_pass_seen, f0 = n_fail_seen;
    wait_ticks(1);
    #1;
    lim_lo = 6'd10; lim_hi = 6'd14; nbits_sel = 2'b00; en = 1'b1;
    cycles(2);
    check(st_startup == 1'b1, "R2 blanking flag", st_startup, 1);
    toggle();
    cycles(2);
    toggle();
    cycles(2);
    toggle();
    wait_ticks(SU - 1);
    check(st_startup == 1'b1, "R2 blanking lasts all ticks", st_startup, 1);
    wait_ticks(1);
    #1;
    check(st_check == 1'b1 && st_startup == 1'b0, "R2 blanking ends", st_check, 1);
    check(n_fail_seen == f0 && n_pass_seen == p0, "R2 edges in blanking ignored",
          n_fail_seen - f0, 0);
    toggle();
    cycles(6);
    check(n_fail_seen == f0 && n_pass_seen == p0 && st_check, "R3 arming edge not judged",
          n_fail_seen - f0, 0);
    wait_ticks(1);
    send_ivl(11);
    send_ivl(12);
    send_ivl(12);
    cycles(5);
    check(n_pass_seen == p0 + 1, "R3 pass after three intervals", n_pass_seen - p0, 1);
    stop_check();
  endtask

  task automatic t_capture();
    int p0 = n_pass_seen, f0 = n_fail_seen;
    start_check(10, 14, 2'b00);
    lim_lo = 6'd20; lim_hi = 6'd30; nbits_sel = 2'b10;
    send_ivl(12);
    send_ivl(12);
    send_ivl(12);
    cycles(5);
    check(n_pass_seen == p0 + 1 && n_fail_seen == f0, "R9 limits captured at start",
          n_pass_seen - p0, 1);
    stop_check();
  endtask

  task automatic t_done_and_restart();
    int p0 = n_pass_seen, f0 = n_fail_seen;
    start_check(10, 14, 2'b00);
    send_ivl(12); send_ivl(12); send_ivl(12);
    cycles(5);
    send_ivl(2);
    send_ivl(2);
    cycles(5);
    check(n_pass_seen == p0 + 1 && n_fail_seen == f0, "R8 single pass and hold",
          n_pass_seen - p0, 1);
    check(st_done == 1'b1, "R8 done until enable drops", st_done, 1);
    @(posedge clk); #1 en = 1'b0;
    cycles(1);
    check(!st_done && !st_check && !st_startup, "R10 idle after enable low", st_done, 0);
    #1 en = 1'b1;
    cycles(1);
    check(st_startup == 1'b1, "R2 new check after re-enable", st_startup, 1);
    stop_check();
  endtask

  task automatic t_en_abort();
    int p0 = n_pass_seen, f0 = n_fail_seen;
    start_check(10, 14, 2'b01);
    send_ivl(12);
    wait_ticks(5);
    #1 en = 1'b0;
    cycles(1);
    check(!st_check && !st_done && !st_startup, "R10 abort to idle", st_check, 0);
    wait_ticks(20);
    cycles(2);
    check(n_pass_seen == p0 && n_fail_seen == f0, "R10 no pulse on abort",
          n_fail_seen - f0, 0);
  endtask

  initial begin
    cycles(3);
    #1 rst_n = 1'b1;
    t_reset();
    t_select(2'b00, 3);
    t_select(2'b01, 6);
    t_select(2'b10, 9);
    t_select(2'b11, 9);
    t_short();
    t_window_edges();
    t_abort(14);
    t_abort(63);
    t_blanking();
    t_capture();
    t_done_and_restart();
    t_en_abort();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule